// File: doc/BRIEF.md
# Honeycomb Router Node with Column-Parity Routing

This block is one switching node of a network-on-chip laid out as a honeycomb. Each node has four ports. The local port connects the attached core. The left and right ports link to the neighbours in the same row. The fourth port is a single vertical link. Its direction depends on the node's column: in an odd column it leads down, and in an even column it leads up. The node's own column and row come in as parameters. A packet can only move vertically in the direction its current column allows, so it reaches its target row by alternating between odd and even columns.

Flits arrive on each input through a valid/ready handshake and wait in a small buffer for that input. The head flit carries the destination coordinates. From them, and from the parity of its own column, the node picks the output port. A round-robin arbiter on each output chooses among the heads that request it. The winning input is then tied to that output until its tail flit has passed, so the body flits follow the head without interleaving. Each output is a register that holds its flit until the downstream side takes it.

Top module: `hc_router`

## Requirements
- R1: Ports are numbered local 0, left 1, right 2, vertical 3. Flit bits [W-1:W-2] hold the type: head 01, body 00, tail 10. The head carries the destination column in bits [W-3 -: C] and the destination row in the C bits below that. A head whose destination equals the node's own column and row leaves on the local port.
- R2: In an odd column, a packet whose destination row is below the node's row (destination row smaller) leaves on the vertical (down) port.
- R3: In an odd column, when the destination row is not smaller than the node's row and the columns differ, the packet leaves on the right port if the destination column is larger and on the left port if it is smaller.
- R4: In an even column, a packet whose destination row is larger than the node's row leaves on the vertical (up) port.
- R5: In an even column, when the destination row is not larger than the node's row and the columns differ, the packet leaves on the right port if the destination column is larger and on the left port if it is smaller.
- R6: When the column already matches but the row does not, and the vertical link of this column points away from the target row, the packet leaves on the left port.
- R7: A flit crosses a link only in a cycle where valid and ready are both high. While an output is valid and not ready, its valid and flit stay unchanged.
- R8: Each input buffers FIFO_DEPTH flits (2 by default). With the output stalled, an input accepts FIFO_DEPTH flits into its buffer plus one into the output register, then holds ready low.
- R9: A packet's flits leave an output back to back, with no flit of another packet between them. Body and tail flits follow the head's port whatever their other bits hold. The output is released only after the tail flit has been forwarded.
- R10: Each output grants among requesting inputs in round-robin order. The search starts at the input after the previous winner, and the first grant after reset searches from input 0.
- R11: After reset, every output's valid is low and every input's ready is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 4 | Flit present on each input port |
| in_ready | output | 4 | Input buffer has room, one bit per port |
| in_flit | input | 4*FLIT_W | Input flits, port p in bits [p*FLIT_W +: FLIT_W] |
| out_valid | output | 4 | Flit present on each output port |
| out_ready | input | 4 | Downstream accepts, one bit per port |
| out_flit | output | 4*FLIT_W | Output flits, port p in bits [p*FLIT_W +: FLIT_W] |

## Verification
The assertions assume well-formed packets on every input. Each packet is a head, zero or more bodies and a tail, and every flit is held stable while valid waits for ready. The direction checks on the local, vertical and right outputs also assume destinations inside the routing rules, with coordinates that fit the C-bit fields. The stimulus produces only such packets, from one task that builds a head, body flits and a tail. That task holds valid and the flit until it sees ready, and it injects on each input from a single process at a time.

// File: rtl/hc_router_pkg.sv
package hc_router_pkg;
  localparam int NPORT  = 4;
  localparam int PIDX_W = 2;

  localparam logic [PIDX_W-1:0] P_LOCAL = 2'd0;
  localparam logic [PIDX_W-1:0] P_LEFT  = 2'd1;
  localparam logic [PIDX_W-1:0] P_RIGHT = 2'd2;
  localparam logic [PIDX_W-1:0] P_VERT  = 2'd3;

  typedef enum logic [1:0] {
    FT_BODY = 2'b00,
    FT_HEAD = 2'b01,
    FT_TAIL = 2'b10
  } ftype_e;
endpackage

// File: rtl/hc_in_fifo.sv
module hc_in_fifo #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             full,
  output logic             empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [CW-1:0]    count;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign rd_data = mem[rptr];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (wr_en) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (rd_en) rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/hc_route_calc.sv
module hc_route_calc
  import hc_router_pkg::*;
#(
  parameter int FLIT_W  = 16,
  parameter int COORD_W = 3,
  parameter int MY_X    = 1,
  parameter int MY_Y    = 1
) (
  input  logic [FLIT_W-1:0] flit,
  output logic [PIDX_W-1:0] port
);
  localparam logic [COORD_W-1:0] CX = COORD_W'(MY_X);
  localparam logic [COORD_W-1:0] CY = COORD_W'(MY_Y);

  logic [COORD_W-1:0] dx, dy;
  logic [PIDX_W-1:0]  horiz;

  assign dx    = flit[FLIT_W-3 -: COORD_W];
  assign dy    = flit[FLIT_W-3-COORD_W -: COORD_W];
  assign horiz = (CX < dx) ? P_RIGHT : P_LEFT;

  generate
    if (MY_X % 2 == 1) begin : g_odd
      always_comb begin
        if (dx == CX && dy == CY) port = P_LOCAL;
        else if (CY > dy)         port = P_VERT;
        else                      port = horiz;
      end
    end else begin : g_even
      always_comb begin
        if (dx == CX && dy == CY) port = P_LOCAL;
        else if (CY < dy)         port = P_VERT;
        else                      port = horiz;
      end
    end
  endgenerate
endmodule

// File: rtl/hc_rr_arb.sv
module hc_rr_arb #(
  parameter int N = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic [N-1:0]         req,
  output logic [N-1:0]         gnt,
  output logic [$clog2(N)-1:0] gnt_idx
);
  localparam int IW = $clog2(N);
  localparam logic [IW-1:0] LAST = IW'(N - 1);

  logic [IW-1:0] ptr;
  logic [IW-1:0] idx;
  logic          found;

  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    found   = 1'b0;
    idx     = '0;
    for (int k = 0; k < N; k++) begin
      idx = IW'((int'(ptr) + k) % N);
      if (en && !found && req[idx]) begin
        found        = 1'b1;
        gnt[idx]     = 1'b1;
        gnt_idx      = idx;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        ptr <= '0;
    else if (found) ptr <= (gnt_idx == LAST) ? '0 : gnt_idx + 1'b1;
  end
endmodule

// File: rtl/hc_router.sv
module hc_router
  import hc_router_pkg::*;
#(
  parameter int FLIT_W     = 16,
  parameter int COORD_W    = 3,
  parameter int MY_X       = 1,
  parameter int MY_Y       = 1,
  parameter int FIFO_DEPTH = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [3:0]              in_valid,
  output logic [3:0]              in_ready,
  input  logic [4*FLIT_W-1:0]     in_flit,
  output logic [3:0]              out_valid,
  input  logic [3:0]              out_ready,
  output logic [4*FLIT_W-1:0]     out_flit
);
  logic [FLIT_W-1:0]  head [NPORT];
  logic [PIDX_W-1:0]  route [NPORT];
  logic [NPORT-1:0]   full, empty, pop, grant_in, in_bound, tail_at;
  logic [NPORT-1:0]   req [NPORT];
  logic [NPORT-1:0]   gnt [NPORT];
  logic [PIDX_W-1:0]  gidx [NPORT];
  logic [NPORT-1:0]   out_lock, move, ov_q;
  logic [NPORT-1:0][PIDX_W-1:0] out_own;
  logic [NPORT-1:0][FLIT_W-1:0] of_q;

  genvar gi, go;
  generate
    for (gi = 0; gi < NPORT; gi++) begin : g_in
      hc_in_fifo #(.WIDTH(FLIT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (in_valid[gi] && !full[gi]),
        .wr_data (in_flit[gi*FLIT_W +: FLIT_W]),
        .rd_en   (pop[gi]),
        .rd_data (head[gi]),
        .full    (full[gi]),
        .empty   (empty[gi])
      );
      hc_route_calc #(.FLIT_W(FLIT_W), .COORD_W(COORD_W), .MY_X(MY_X), .MY_Y(MY_Y)) u_route (
        .flit (head[gi]),
        .port (route[gi])
      );
      assign in_ready[gi] = !full[gi];
      assign tail_at[gi]  = (head[gi][FLIT_W-1 -: 2] == FT_TAIL);
    end

    for (go = 0; go < NPORT; go++) begin : g_out
      always_comb begin
        for (int i = 0; i < NPORT; i++)
          req[go][i] = !empty[i] && !in_bound[i] &&
                       (head[i][FLIT_W-1 -: 2] == FT_HEAD) &&
                       (route[i] == PIDX_W'(go));
      end
      hc_rr_arb #(.N(NPORT)) u_arb (
        .clk     (clk),
        .rst     (rst),
        .en      (!out_lock[go]),
        .req     (req[go]),
        .gnt     (gnt[go]),
        .gnt_idx (gidx[go])
      );
      assign out_valid[go]                   = ov_q[go];
      assign out_flit[go*FLIT_W +: FLIT_W]   = of_q[go];
    end
  endgenerate

  always_comb begin
    pop      = '0;
    grant_in = '0;
    for (int o = 0; o < NPORT; o++) begin
      move[o] = out_lock[o] && !empty[out_own[o]] && (!ov_q[o] || out_ready[o]);
      if (move[o]) pop[out_own[o]] = 1'b1;
      grant_in = grant_in | gnt[o];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_lock <= '0;
      out_own  <= '0;
      ov_q     <= '0;
      in_bound <= '0;
    end else begin
      for (int o = 0; o < NPORT; o++) begin
        if (!out_lock[o] && |gnt[o]) begin
          out_lock[o] <= 1'b1;
          out_own[o]  <= gidx[o];
        end
        if (move[o]) begin
          ov_q[o] <= 1'b1;
          if (tail_at[out_own[o]]) out_lock[o] <= 1'b0;
        end else if (out_ready[o]) begin
          ov_q[o] <= 1'b0;
        end
      end
      for (int i = 0; i < NPORT; i++) begin
        if (grant_in[i])               in_bound[i] <= 1'b1;
        else if (pop[i] && tail_at[i]) in_bound[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int o = 0; o < NPORT; o++)
      if (move[o]) of_q[o] <= head[out_own[o]];
  end
endmodule

// File: rtl/hc_router_chk.sv
module hc_router_chk
  import hc_router_pkg::*;
#(
  parameter int FLIT_W  = 16,
  parameter int COORD_W = 3,
  parameter int MY_X    = 1,
  parameter int MY_Y    = 1
) (
  input logic                          clk,
  input logic                          rst,
  input logic [3:0]                    out_valid,
  input logic [3:0]                    out_ready,
  input logic [4*FLIT_W-1:0]           out_flit,
  input logic [3:0]                    lock,
  input logic [3:0][PIDX_W-1:0]        own
);
  localparam logic [COORD_W-1:0] CX = COORD_W'(MY_X);
  localparam logic [COORD_W-1:0] CY = COORD_W'(MY_Y);
  localparam bit ODD = (MY_X % 2 == 1);

  logic [FLIT_W-1:0]  f [NPORT];
  logic               is_head [NPORT];
  logic [COORD_W-1:0] fx [NPORT];
  logic [COORD_W-1:0] fy [NPORT];
  logic [NPORT-1:0]   held_by [NPORT];

  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      f[p]       = out_flit[p*FLIT_W +: FLIT_W];
      is_head[p] = (f[p][FLIT_W-1 -: 2] == FT_HEAD);
      fx[p]      = f[p][FLIT_W-3 -: COORD_W];
      fy[p]      = f[p][FLIT_W-3-COORD_W -: COORD_W];
      for (int o = 0; o < NPORT; o++)
        held_by[p][o] = lock[o] && (own[o] == PIDX_W'(p));
    end
  end

  genvar g;
  generate
    for (g = 0; g < NPORT; g++) begin : g_port
      // R7
      out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid[g] && !out_ready[g] |=> out_valid[g] && $stable(out_flit[g*FLIT_W +: FLIT_W]));
      // R9
      single_path_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(held_by[g]));
    end
  endgenerate

  // R1
  local_dest_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid[0] && is_head[0] |-> fx[0] == CX && fy[0] == CY);
  // R2
  vert_dir_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid[3] && is_head[3] |-> (ODD ? (fy[3] < CY) : (fy[3] > CY)));
  // R3
  right_dir_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid[2] && is_head[2] |-> fx[2] > CX);
endmodule

bind hc_router hc_router_chk #(
  .FLIT_W(FLIT_W), .COORD_W(COORD_W), .MY_X(MY_X), .MY_Y(MY_Y)
) u_chk (
  .clk(clk), .rst(rst), .out_valid(out_valid), .out_ready(out_ready),
  .out_flit(out_flit), .lock(out_lock), .own(out_own)
);

// File: tb/hc_router_tb_top.sv
module hc_router_tb_top;
  localparam int FW = 16;
  localparam int DEPTH = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [3:0]      iv   [2];
  logic [3:0]      ir   [2];
  logic [4*FW-1:0] ifl  [2];
  logic [3:0]      ov   [2];
  logic [3:0]      ordy [2];
  logic [4*FW-1:0] ofl  [2];

  hc_router #(.FLIT_W(FW), .COORD_W(3), .MY_X(1), .MY_Y(1), .FIFO_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .in_valid(iv[0]), .in_ready(ir[0]), .in_flit(ifl[0]),
    .out_valid(ov[0]), .out_ready(ordy[0]), .out_flit(ofl[0]));

  hc_router #(.FLIT_W(FW), .COORD_W(3), .MY_X(2), .MY_Y(1), .FIFO_DEPTH(DEPTH)) dut_e (
    .clk(clk), .rst(rst), .in_valid(iv[1]), .in_ready(ir[1]), .in_flit(ifl[1]),
    .out_valid(ov[1]), .out_ready(ordy[1]), .out_flit(ofl[1]));

  int checks = 0;
  int errors = 0;
  logic [FW-1:0] rq [8][$];
  logic [FW-1:0] eq [8][$];
  int rrp [2][4];
  int acc [2][4];

  always @(negedge clk) begin
    for (int d = 0; d < 2; d++)
      for (int p = 0; p < 4; p++)
        if (!rst && ov[d][p] && ordy[d][p]) rq[d*4+p].push_back(ofl[d][p*FW +: FW]);
  end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] mk_flit(int k, int len, int dx, int dy, int tag);
    if (k == 0) return {2'b01, 3'(dx), 3'(dy), 8'(tag)};
    return {(k == len-1) ? 2'b10 : 2'b00, 6'(tag), 8'(k)};
  endfunction

  task automatic send_pkt(int d, int ip, int xp, int dx, int dy, int len, int tag, bit rec);
    for (int k = 0; k < len; k++) begin
      logic [FW-1:0] fl;
      fl = mk_flit(k, len, dx, dy, tag);
      if (rec) eq[d*4+xp].push_back(fl);
      @(negedge clk);
      iv[d][ip] = 1'b1;
      ifl[d][ip*FW +: FW] = fl;
      while (!ir[d][ip]) @(negedge clk);
      acc[d][ip]++;
      @(posedge clk);
    end
    @(negedge clk);
    iv[d][ip] = 1'b0;
  endtask

  task automatic check_port(int d, int p, string req);
    int n;
    repeat (20) @(negedge clk);
    n = eq[d*4+p].size();
    chk(rq[d*4+p].size() == n, req, "flit count", rq[d*4+p].size(), n);
    for (int k = 0; k < n && k < rq[d*4+p].size(); k++)
      if (rq[d*4+p][k] !== eq[d*4+p][k])
        chk(1'b0, req, "flit value", rq[d*4+p][k], eq[d*4+p][k]);
    for (int q = 0; q < 8; q++) begin
      if (q != d*4+p) chk(rq[q].size() == eq[q].size(), req, "no stray flits", rq[q].size(), eq[q].size());
      rq[q].delete();
      eq[q].delete();
    end
  endtask

  task automatic route_case(int d, int ip, int dx, int dy, int xp, string req);
    send_pkt(d, ip, xp, dx, dy, 3, 8'h10 + ip, 1'b1);
    rrp[d][xp] = (ip + 1) % 4;
    check_port(d, xp, req);
  endtask

  function automatic int rr_first(int d, int o, int a, int b);
    for (int k = 0; k < 4; k++) begin
      int c;
      c = (rrp[d][o] + k) % 4;
      if (c == a || c == b) return c;
    end
    return a;
  endfunction

  task automatic t_reset();
    for (int d = 0; d < 2; d++) begin
      chk(ov[d] == 4'h0, "R11", "out_valid after reset", ov[d], 0);
      chk(ir[d] == 4'hF, "R11", "in_ready after reset", ir[d], 4'hF);
    end
  endtask

  task automatic t_odd_routes();
    route_case(0, 1, 1, 1, 0, "R1");
    route_case(0, 0, 1, 0, 3, "R2");
    route_case(0, 2, 3, 0, 3, "R2");
    route_case(0, 3, 3, 2, 2, "R3");
    route_case(0, 0, 0, 1, 1, "R3");
    route_case(0, 2, 1, 3, 1, "R6");
  endtask

  task automatic t_even_routes();
    route_case(1, 0, 2, 3, 3, "R4");
    route_case(1, 1, 0, 2, 3, "R4");
    route_case(1, 2, 3, 0, 2, "R5");
    route_case(1, 3, 1, 1, 1, "R5");
    route_case(1, 1, 2, 0, 1, "R6");
    route_case(1, 3, 2, 1, 0, "R1");
  endtask

  task automatic t_contend(int a, int b, string req);
    int w, l;
    w = rr_first(1, 2, a, b);
    l = (w == a) ? b : a;
    for (int k = 0; k < 4; k++) eq[6].push_back(mk_flit(k, 4, 3, 0, 8'h20 + w));
    for (int k = 0; k < 4; k++) eq[6].push_back(mk_flit(k, 4, 3, 0, 8'h20 + l));
    fork
      send_pkt(1, a, 2, 3, 0, 4, 8'h20 + a, 1'b0);
      send_pkt(1, b, 2, 3, 0, 4, 8'h20 + b, 1'b0);
    join
    rrp[1][2] = (l + 1) % 4;
    check_port(1, 2, req);
  endtask

  task automatic t_backpressure();
    logic [FW-1:0] first;
    first = mk_flit(0, 5, 1, 1, 8'h33);
    for (int k = 0; k < 4; k++) acc[0][k] = 0;
    @(posedge clk); #2;
    ordy[0][0] = 1'b0;
    fork
      send_pkt(0, 2, 0, 1, 1, 5, 8'h33, 1'b1);
      begin
        repeat (15) @(negedge clk);
        chk(acc[0][2] == DEPTH + 1, "R8", "flits accepted while stalled", acc[0][2], DEPTH + 1);
        chk(ir[0][2] == 1'b0, "R8", "ready low when full", ir[0][2], 0);
        chk(ov[0][0] == 1'b1, "R7", "valid held while stalled", ov[0][0], 1);
        chk(ofl[0][0 +: FW] == first, "R7", "flit held while stalled", ofl[0][0 +: FW], first);
        repeat (3) @(negedge clk);
        chk(ofl[0][0 +: FW] == first && ov[0][0], "R7", "flit stable", ofl[0][0 +: FW], first);
        chk(rq[0].size() == 0, "R7", "no transfer without ready", rq[0].size(), 0);
        @(posedge clk); #2;
        ordy[0][0] = 1'b1;
      end
    join
    rrp[0][0] = 3;
    check_port(0, 0, "R7");
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int d = 0; d < 2; d++) begin
      iv[d] = '0; ifl[d] = '0; ordy[d] = 4'hF;
      for (int p = 0; p < 4; p++) begin rrp[d][p] = 0; acc[d][p] = 0; end
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_odd_routes();
    t_even_routes();
    t_contend(0, 1, "R9");
    t_contend(0, 1, "R10");
    t_contend(1, 3, "R10");
    t_backpressure();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule